// File: doc/BRIEF.md
# Global Memory Window Decoder

This block sits between a processor's data port and an external data bus with a 16-bit word address. An 8-bit allocation mask, held in a register that the processor reaches at data address 5, marks a window at the top of the address map as shared (global) memory. Every other external address is local. Every data access is classed as one of three kinds: a register access, a local access or a global access. A local access goes straight to the external bus with the data strobe and finishes in one cycle. A global access also lowers a bus-request strobe, and it is held until the external arbiter raises ready.

The processor side is a valid/ready port. The master raises `acc_valid` together with the address, direction and write data. It must hold all of them unchanged while `acc_ready` is low. The access completes in the cycle where both are high, and read data is taken in that same cycle. Only a global access can hold `acc_ready` low.

Top module: `gmem_window_dec`

## Requirements
- R1: After reset the mask register reads 00h, and every external address is treated as local.
- R2: A write to address 5 stores the low 8 bits of the write data in the mask register when the clock edge completes it. A read of address 5 returns FFh in bits 15:8 and the mask in bits 7:0.
- R3: Accesses to address 5 are internal. `ext_ds_n` and `ext_br_n` stay high, `ext_we` stays low, and the access completes in one cycle.
- R4: An address is global when the mask has a one in any of bits 7:2 and (address[15:8] AND mask) equals the mask. With mask C0h, for example, the global range is C000h to FFFFh.
- R5: Mask values 00h to 03h leave no global region. Every address is local under these values.
- R6: During a global access `ext_ds_n` and `ext_br_n` are both low, and `acc_ready` follows `ext_ready`. The access does not complete while `ext_ready` is low.
- R7: During a local access `ext_ds_n` is low and `ext_br_n` is high. `acc_ready` is high whatever the level of `ext_ready`.
- R8: Mask values that are not a left-aligned run of ones are stored as written and applied with the same AND compare. No error is raised.
- R9: External accesses pass the address and write data through. `ext_we` is high only for an external write, and the read data returned is `ext_rdata`.
- R10: A new mask takes effect in the very next cycle after the write completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Processor access request |
| acc_ready | output | 1 | Access completes this cycle |
| acc_addr | input | 16 | Data word address |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid when the access completes |
| ext_ds_n | output | 1 | External data strobe, active low |
| ext_br_n | output | 1 | Global bus request, active low |
| ext_we | output | 1 | External write enable |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| ext_ready | input | 1 | Arbiter grant, ends a global access |

## Verification
Two functions can meet at one clock edge: a write that changes the mask, and the decode of the access that follows it. The bench provokes this by writing a new mask and then presenting an address at once. It picks addresses that change class under the new value, such as C000h after the mask moves from C0h to E0h, and checks `ext_br_n` in the very next cycle. The wait handshake is judged as well. During a global stall the bench holds `ext_ready` low for several cycles and checks that `acc_ready` stays low while both strobes stay asserted. A local access made with `ext_ready` low must still complete at once.

// File: rtl/gwd_pkg.sv
package gwd_pkg;
  typedef enum logic [1:0] {
    KIND_IDLE   = 2'd0,
    KIND_REG    = 2'd1,
    KIND_LOCAL  = 2'd2,
    KIND_GLOBAL = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/gwd_mask_reg.sv
module gwd_mask_reg #(
  parameter int DATA_W = 16,
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MASK_W-1:0] wr_mask,
  output logic [MASK_W-1:0] mask,
  output logic [DATA_W-1:0] rd_word
);
  localparam int PAD_W = DATA_W - MASK_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask <= '0;
    else if (wr_en) mask <= wr_mask;
  end

  assign rd_word = {{PAD_W{1'b1}}, mask};

  // R2
  mask_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask) |-> $past(wr_en));
endmodule

// File: rtl/gwd_window_cmp.sv
module gwd_window_cmp #(
  parameter int ADDR_W     = 16,
  parameter int MASK_W     = 8,
  parameter int NOGLOB_LSB = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [MASK_W-1:0] mask,
  output logic              hit
);
  localparam int TOP_LSB = ADDR_W - MASK_W;

  logic [MASK_W-1:0] bit_ok;

  generate
    for (genvar i = 0; i < MASK_W; i++) begin : g_bit
      assign bit_ok[i] = ~mask[i] | addr[TOP_LSB + i];
    end
  endgenerate

  assign hit = (&bit_ok) & (|mask[MASK_W-1:NOGLOB_LSB]);
endmodule

// File: rtl/gwd_bus_seq.sv
module gwd_bus_seq
  import gwd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      acc_valid,
  input  logic      is_reg,
  input  logic      hit,
  input  logic      ext_ready,
  output acc_kind_e kind,
  output logic      acc_ready,
  output logic      ext_ds_n,
  output logic      ext_br_n
);
  always_comb begin
    if (!acc_valid)  kind = KIND_IDLE;
    else if (is_reg) kind = KIND_REG;
    else if (hit)    kind = KIND_GLOBAL;
    else             kind = KIND_LOCAL;
  end

  always_comb begin
    acc_ready = 1'b1;
    ext_ds_n  = 1'b1;
    ext_br_n  = 1'b1;
    unique case (kind)
      KIND_LOCAL:  ext_ds_n = 1'b0;
      KIND_GLOBAL: begin
        ext_ds_n  = 1'b0;
        ext_br_n  = 1'b0;
        acc_ready = ext_ready;
      end
      default: ;
    endcase
  end

  // R6
  br_with_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_br_n |-> !ext_ds_n);

  // R7
  stall_only_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready) |-> (!ext_br_n && !ext_ready));

  // R6
  stall_holds_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready) |=> (acc_valid && !ext_br_n));
endmodule

// File: rtl/gmem_window_dec.sv
module gmem_window_dec
  import gwd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int MASK_W     = 8,
  parameter int REG_ADDR   = 5,
  parameter int NOGLOB_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_we,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              ext_ds_n,
  output logic              ext_br_n,
  output logic              ext_we,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic [DATA_W-1:0] ext_rdata,
  input  logic              ext_ready
);
  localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(REG_ADDR);

  logic              is_reg;
  logic              hit;
  logic              reg_wr;
  logic [MASK_W-1:0] mask;
  logic [DATA_W-1:0] reg_word;
  acc_kind_e         kind;

  assign is_reg = (acc_addr == REG_A);
  assign reg_wr = acc_valid & acc_we & is_reg;

  gwd_mask_reg #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr),
    .wr_mask(acc_wdata[MASK_W-1:0]), .mask(mask), .rd_word(reg_word)
  );

  gwd_window_cmp #(.ADDR_W(ADDR_W), .MASK_W(MASK_W), .NOGLOB_LSB(NOGLOB_LSB)) u_cmp (
    .addr(acc_addr), .mask(mask), .hit(hit)
  );

  gwd_bus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .is_reg(is_reg),
    .hit(hit), .ext_ready(ext_ready), .kind(kind), .acc_ready(acc_ready),
    .ext_ds_n(ext_ds_n), .ext_br_n(ext_br_n)
  );

  assign ext_addr  = acc_addr;
  assign ext_wdata = acc_wdata;
  assign ext_we    = (kind == KIND_LOCAL || kind == KIND_GLOBAL) & acc_we;
  assign acc_rdata = is_reg ? reg_word : ext_rdata;

  // R3
  reg_stays_internal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && is_reg) |-> (ext_ds_n && ext_br_n && !ext_we && acc_ready));

  // R5
  low_mask_no_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[MASK_W-1:NOGLOB_LSB] == '0) |-> ext_br_n);
endmodule

// File: tb/gmem_window_dec_test.sv
module gmem_window_dec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [15:0] acc_addr = '0;
  logic        acc_we = 1'b0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] acc_rdata;
  logic        ext_ds_n, ext_br_n, ext_we;
  logic [15:0] ext_addr, ext_wdata, ext_rdata;
  logic        ext_ready = 1'b1;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign ext_rdata = ext_addr ^ 16'hA5C3;

  gmem_window_dec uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .ext_ds_n(ext_ds_n), .ext_br_n(ext_br_n),
    .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata), .ext_ready(ext_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_global(input logic [7:0] m, input logic [15:0] a);
    return (m[7:2] != 0) && ((a[15:8] & m) == m);
  endfunction

  task automatic write_mask(input logic [7:0] m);
    @(negedge clk);
    acc_valid = 1'b1; acc_we = 1'b1; acc_addr = 16'd5; acc_wdata = {8'h3C, m};
    #5;
    chk(ext_ds_n && ext_br_n && !ext_we && acc_ready, "R3",
        {ext_ds_n, ext_br_n, ext_we, acc_ready}, 4'b1101);
    @(posedge clk);
  endtask

  task automatic read_check(input logic [7:0] m, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_we = 1'b0; acc_addr = 16'd5;
    #5;
    chk(acc_rdata == {8'hFF, m}, req, acc_rdata, {8'hFF, m});
    chk(ext_ds_n && ext_br_n, "R3", {ext_ds_n, ext_br_n}, 2'b11);
    @(posedge clk);
  endtask

  task automatic probe(input logic [7:0] m, input logic [15:0] a, input string req);
    bit g;
    @(negedge clk);
    acc_valid = 1'b1; acc_we = a[0]; acc_addr = a; acc_wdata = ~a;
    #5;
    g = exp_global(m, a);
    chk(ext_br_n == !g, req, ext_br_n, !g);
    chk(!ext_ds_n && acc_ready && ext_we == a[0] && ext_addr == a
        && ext_wdata == ~a && (a[0] || acc_rdata == (a ^ 16'hA5C3)), "R9",
        {ext_ds_n, acc_ready, ext_we}, {1'b0, 1'b1, a[0]});
    @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] masks [14];
    masks = '{8'h80, 8'hC0, 8'hE0, 8'hF0, 8'hF8, 8'hFC, 8'hFE, 8'hFF,
              8'h00, 8'h01, 8'h02, 8'h03, 8'hA0, 8'h24};
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    read_check(8'h00, "R1");
    probe(8'h00, 16'hFFFF, "R1");

    for (int k = 0; k < 14; k++) begin
      write_mask(masks[k]);
      read_check(masks[k], "R2");
      for (int h = 0; h < 256; h++) begin
        logic [15:0] a;
        a = {h[7:0], h[7:0] ^ 8'h5A};
        probe(masks[k], a, masks[k] < 8'h04 ? "R5" :
              (k >= 12 ? "R8" : "R4"));
      end
    end

    // R10 back-to-back: mask change decoded in the next cycle
    write_mask(8'hC0);
    probe(8'hC0, 16'hC000, "R10");
    write_mask(8'hE0);
    probe(8'hE0, 16'hC000, "R10");
    probe(8'hE0, 16'hE000, "R10");

    // R6 stall until ready
    write_mask(8'h80);
    @(negedge clk);
    ext_ready = 1'b0; acc_valid = 1'b1; acc_we = 1'b0; acc_addr = 16'h8123;
    for (int c = 0; c < 4; c++) begin
      #5;
      chk(!acc_ready && !ext_br_n && !ext_ds_n, "R6",
          {acc_ready, ext_br_n, ext_ds_n}, 3'b000);
      @(negedge clk);
    end
    ext_ready = 1'b1;
    #5;
    chk(acc_ready && acc_rdata == (16'h8123 ^ 16'hA5C3), "R6", acc_rdata,
        16'h8123 ^ 16'hA5C3);
    @(posedge clk);

    // R7 local completes while ready low
    @(negedge clk);
    ext_ready = 1'b0; acc_addr = 16'h1234;
    #5;
    chk(acc_ready && ext_br_n && !ext_ds_n, "R7",
        {acc_ready, ext_br_n, ext_ds_n}, 3'b110);
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0; ext_ready = 1'b1;
    #5;
    chk(ext_ds_n && ext_br_n, "R9", {ext_ds_n, ext_br_n}, 2'b11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule